// File: doc/BRIEF.md
# Register-Mapped 32-bit Adder Coprocessor

This block is a small coprocessor on a 32-bit register bus. It holds two operand registers and one result register. Software never addresses an operand directly. It first writes a command word whose select bits choose one operand. Reads and writes through a single data window then reach that operand. A command write with the go bit set makes the block add the two operands and capture the sum. Software reads the sum at the next bus transaction.

The bus has a byte address, a write strobe with write data, and a read strobe. Each request lasts one cycle. The block answers every request with a one-cycle acknowledge in the following cycle. Read data is registered and is valid while the acknowledge is high.

Top module: `sum_engine`

## Requirements
- R1: Four word offsets are decoded: 0x0 is a status word, 0x4 is the command word, 0x8 is the data window and 0xC is the result. Any other address, including one that is not word aligned, is unmapped: it reads 0 and a write to it changes nothing. The status word always reads 0.
- R2: A request is a cycle with the read strobe or the write strobe high. The acknowledge is high in exactly the cycle after each request and low otherwise. Read data is valid in the acknowledge cycle and is 0 when the preceding cycle held no read.
- R3: Command bit 1 selects operand A and bit 2 selects operand B; every command write stores both bits. A command read returns the two stored bits in positions 1 and 2, with bit 0 and bits 31..3 reading 0.
- R4: A data window write stores all 32 bits into the selected operand. A data window read returns that operand unchanged (0xff11ee22 reads back as 0xff11ee22).
- R5: When bits 1 and 2 are both set, operand A is the target of window reads and writes, and operand B is left unchanged.
- R6: When neither select bit is set, window writes change neither operand and window reads return 0.
- R7: A command write with bit 0 set stores A+B modulo 2^32 into the result, with the carry out discarded. The result can be read at the very next transaction. Bit 0 is never stored.
- R8: The result holds its value until the next add command. Writes to the result and status offsets have no effect.
- R9: Reset (active low) clears both operands, the result and both select bits, and drops the acknowledge.
- R10: The sequence command 0x2, window 1, command 0x4, window 2, command 0x1, read result returns 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the request |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge, the cycle after a request |

## Verification
The operand, select and result registers are reachable only through the bus. A wrong select state therefore appears as a wrong window readback or a wrong command readback. It shows one cycle after the read request, in the acknowledge cycle. A wrong operand or adder path appears in the result read that immediately follows the add command, so every check samples in the acknowledge cycle of a read. A write that must be ignored is followed by a read of the state it could have touched, which turns any corruption into a visible wrong value one transaction later.

// File: rtl/sum_engine_pkg.sv
// Package: shared definitions for the register-mapped adder.
// Assumes word-aligned byte addressing with four 32-bit slots.
package sum_engine_pkg;

    // Word slot index, taken from address bits [3:2]
    typedef enum logic [1:0] {
        SLOT_STAT = 2'd0,
        SLOT_CTRL = 2'd1,
        SLOT_WIN  = 2'd2,
        SLOT_SUM  = 2'd3
    } slot_e;

    // Command word bit positions (software depends on these)
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_SELA_BIT = 1;
    localparam int CMD_SELB_BIT = 2;

    // Decoded access strobes for one bus cycle
    typedef struct packed {
        logic ctrl_wr;
        logic win_wr;
        logic add_go;
    } wr_hits_t;

endpackage

// File: rtl/sum_engine_decode.sv
// Module: address decoder.
// Maps a byte address onto one of four word slots. Any address with
// nonzero low bits or nonzero bits above the slot field is unmapped.
// Assumes ADDR_W >= 5 so that an unmapped range exists.
module sum_engine_decode
    import sum_engine_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped,
    output slot_e             slot
);

    localparam int SLOT_LSB = 2;
    localparam int HIGH_LSB = 4;

    // Check alignment and range, then extract the slot field
    always_comb begin
        mapped = (addr[SLOT_LSB-1:0] == '0) && (addr[ADDR_W-1:HIGH_LSB] == '0);
        slot   = slot_e'(addr[HIGH_LSB-1:SLOT_LSB]);
    end

endmodule

// File: rtl/sum_engine_operands.sv
// Module: select bits and operand bank.
// Holds the two select bits and the A/B operand registers. The window
// reaches A when its select is set (A wins over B), else B when its
// select is set, else nothing. Assumes the write strobes are already
// decoded and last one cycle.
module sum_engine_operands
    import sum_engine_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              win_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sel_a,
    output logic              sel_b,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] win_rdata
);

    logic tgt_a;
    logic tgt_b;

    // Resolve the window target with A taking priority
    always_comb begin
        tgt_a = sel_a;
        tgt_b = sel_b && !sel_a;
    end

    // Store both select bits on every command write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a <= 1'b0;
            sel_b <= 1'b0;
        end else if (ctrl_wr) begin
            sel_a <= wdata[CMD_SELA_BIT];
            sel_b <= wdata[CMD_SELB_BIT];
        end
    end

    // Load operand A from the window when it is the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
        end else if (win_wr && tgt_a) begin
            opa <= wdata;
        end
    end

    // Load operand B from the window when it is the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opb <= '0;
        end else if (win_wr && tgt_b) begin
            opb <= wdata;
        end
    end

    // Return the targeted operand, or zero with no target
    always_comb begin
        if (tgt_a) begin
            win_rdata = opa;
        end else if (tgt_b) begin
            win_rdata = opb;
        end else begin
            win_rdata = '0;
        end
    end

endmodule

// File: rtl/sum_engine_adder.sv
// Module: adder and result register.
// Adds the operands combinationally and captures the sum on the edge
// that takes the go command. The carry out is dropped. Assumes the
// operands are stable during the command cycle.
module sum_engine_adder #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_go,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum_q
);

    logic [DATA_W:0] carry;
    logic [DATA_W-1:0] sum_d;

    assign carry[0] = 1'b0;

    // Ripple chain, one full adder per bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            sum_d[i]   = opa[i] ^ opb[i] ^ carry[i];
            carry[i+1] = (opa[i] & opb[i]) | (carry[i] & (opa[i] ^ opb[i]));
        end
    end

    // Capture the sum on a go command; hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (add_go) begin
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/sum_engine.sv
// Module: register-mapped 32-bit adder coprocessor (top).
// Decodes single-cycle bus requests, routes writes into the select bits
// and the operand bank, and triggers the adder. Read data and the
// acknowledge are registered, one cycle after the request.
// Assumes requests last one cycle and that a cycle with both strobes
// performs the write and returns the value from before that write.
module sum_engine
    import sum_engine_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack
);

    logic              mapped;
    slot_e             slot;
    wr_hits_t          hits;
    logic              sel_a;
    logic              sel_b;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] win_rdata;
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] rd_mux;

    sum_engine_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .mapped (mapped),
        .slot   (slot)
    );

    // Qualify the write strobe with the decoded slot
    always_comb begin
        hits.ctrl_wr = bus_wr && mapped && (slot == SLOT_CTRL);
        hits.win_wr  = bus_wr && mapped && (slot == SLOT_WIN);
        hits.add_go  = hits.ctrl_wr && bus_wdata[CMD_GO_BIT];
    end

    sum_engine_operands #(.DATA_W(DATA_W)) u_ops (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (hits.ctrl_wr),
        .win_wr    (hits.win_wr),
        .wdata     (bus_wdata),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .opa       (opa),
        .opb       (opb),
        .win_rdata (win_rdata)
    );

    sum_engine_adder #(.DATA_W(DATA_W)) u_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_go (hits.add_go),
        .opa    (opa),
        .opb    (opb),
        .sum_q  (sum_q)
    );

    // Select the read value for the addressed slot
    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            unique case (slot)
                SLOT_STAT: rd_mux = '0;
                SLOT_CTRL: begin
                    rd_mux[CMD_SELA_BIT] = sel_a;
                    rd_mux[CMD_SELB_BIT] = sel_b;
                end
                SLOT_WIN:  rd_mux = win_rdata;
                SLOT_SUM:  rd_mux = sum_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    // Register the read data and the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_ack   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
            bus_ack   <= bus_rd || bus_wr;
        end
    end

endmodule

// File: rtl/sum_engine_chk.sv
// Module: protocol and state checker for sum_engine, bound to the top.
// Observes bus ports and the operand, select and result state.
module sum_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ack,
    input logic              sel_a,
    input logic              sel_b,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] sum_q
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(8);

    logic go_now;
    assign go_now = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ack);  // R2
    AST_NO_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_ack);  // R2
    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> (bus_rdata == '0));  // R1
    AST_CMD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CTRL) |=>
        (bus_rdata[DATA_W-1:3] == '0) && !bus_rdata[0]
        && (bus_rdata[2] == $past(sel_b)) && (bus_rdata[1] == $past(sel_a)));  // R3
    AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_WIN && sel_a) |=>
        (opa == $past(bus_wdata)) && $stable(opb));  // R5
    AST_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_WIN && !sel_a && !sel_b) |=>
        $stable(opa) && $stable(opb));  // R6
    AST_SUM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        go_now |=> (sum_q == $past(opa + opb)));  // R7
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !go_now |=> $stable(sum_q));  // R8

endmodule

bind sum_engine sum_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .opa       (opa),
    .opb       (opb),
    .sum_q     (sum_q)
);

// File: tb/sum_engine_tb.sv
// Bench: a vector table of operand pairs walked by one loop, then
// directed tests for reset, selection, ignored writes and decode.
module sum_engine_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] O_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] O_CTRL = 8'h04;
    localparam logic [ADDR_W-1:0] O_WIN  = 8'h08;
    localparam logic [ADDR_W-1:0] O_SUM  = 8'h0C;
    localparam int NVEC = 8;

    // {a, b, expected sum}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'h0000_0001, 32'h0000_0002, 32'h0000_0003},
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {32'hFF11_EE22, 32'h00EE_11DE, 32'h0000_0000},
        {32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
        {32'h1234_5678, 32'h1111_1111, 32'h2345_6789},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hDEAD_BEEF, 32'h0000_0001, 32'hDEAD_BEF0},
        {32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_ack;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sum_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (bus_ack !== 1'b1) check("R2 write ack", {31'b0, bus_ack}, 32'd1);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (bus_ack !== 1'b1) check("R2 read ack", {31'b0, bus_ack}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rv;
        logic [DATA_W-1:0] a_exp;

        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ack low after reset", {31'b0, bus_ack}, 32'd0);
        bus_read(O_SUM, rv);  check("R9 result cleared", rv, 32'd0);
        bus_read(O_CTRL, rv); check("R9 selects cleared", rv, 32'd0);
        bus_read(O_WIN, rv);  check("R6 window no target reads 0", rv, 32'd0);
        bus_write(O_CTRL, 32'h2);
        bus_read(O_WIN, rv);  check("R9 operand A cleared", rv, 32'd0);
        bus_write(O_CTRL, 32'h4);
        bus_read(O_WIN, rv);  check("R9 operand B cleared", rv, 32'd0);
        @(negedge clk);
        check("R2 ack low when idle", {31'b0, bus_ack}, 32'd0);
        check("R2 rdata zero when idle", bus_rdata, 32'd0);

        // Vector loop: load, add, read result at once
        for (int v = 0; v < NVEC; v++) begin
            bus_write(O_CTRL, 32'h2);
            bus_write(O_WIN, VEC[v][95:64]);
            bus_write(O_CTRL, 32'h4);
            bus_write(O_WIN, VEC[v][63:32]);
            bus_write(O_CTRL, 32'h2);
            bus_read(O_WIN, rv);
            check("R4 operand A readback", rv, VEC[v][95:64]);
            bus_write(O_CTRL, 32'h1);
            bus_read(O_SUM, rv);
            check("R7 sum modulo 2^32", rv, VEC[v][31:0]);
        end

        // Driver sequence 1 + 2
        bus_write(O_CTRL, 32'h2);
        bus_write(O_WIN, 32'd1);
        bus_write(O_CTRL, 32'h4);
        bus_write(O_WIN, 32'd2);
        bus_write(O_CTRL, 32'h1);
        bus_read(O_SUM, rv);
        check("R10 driver sequence", rv, 32'd3);

        // Round trip of the test pattern
        bus_write(O_CTRL, 32'h2);
        bus_write(O_WIN, 32'hFF11_EE22);
        bus_read(O_WIN, rv);
        check("R4 window round trip", rv, 32'hFF11_EE22);

        // Command readback masks bit 0 and high bits
        bus_write(O_CTRL, 32'hFFFF_FFFE);
        bus_read(O_CTRL, rv);
        check("R3 command readback", rv, 32'h6);
        bus_write(O_CTRL, 32'h0000_0005);
        bus_read(O_CTRL, rv);
        check("R3 go bit not stored", rv, 32'h4);

        // Both selects: A wins, B untouched (B currently 2)
        bus_write(O_CTRL, 32'h6);
        bus_write(O_WIN, 32'hAAAA_5555);
        bus_read(O_WIN, rv);
        check("R5 both selected reads A", rv, 32'hAAAA_5555);
        bus_write(O_CTRL, 32'h4);
        bus_read(O_WIN, rv);
        check("R5 B unchanged", rv, 32'd2);
        bus_write(O_CTRL, 32'h2);
        bus_read(O_WIN, rv);
        check("R5 A written", rv, 32'hAAAA_5555);
        a_exp = 32'hAAAA_5555;

        // No target: write ignored, read zero
        bus_write(O_CTRL, 32'h0);
        bus_write(O_WIN, 32'h1357_9BDF);
        bus_read(O_WIN, rv);
        check("R6 no target read zero", rv, 32'd0);
        bus_write(O_CTRL, 32'h2);
        bus_read(O_WIN, rv);
        check("R6 A kept", rv, a_exp);
        bus_write(O_CTRL, 32'h4);
        bus_read(O_WIN, rv);
        check("R6 B kept", rv, 32'd2);

        // Add with both operands known, then result holds
        bus_write(O_CTRL, 32'h1);
        bus_read(O_SUM, rv);
        check("R7 sum after select change", rv, 32'hAAAA_5557);
        bus_write(O_SUM, 32'h0BAD_0BAD);
        bus_write(O_STAT, 32'hFFFF_FFFF);
        bus_write(O_CTRL, 32'h2);
        bus_write(O_WIN, 32'd7);
        bus_read(O_SUM, rv);
        check("R8 result holds", rv, 32'hAAAA_5557);
        bus_read(O_STAT, rv);
        check("R1 status reads zero", rv, 32'd0);

        // Unmapped addresses
        bus_read(8'h10, rv);
        check("R1 unmapped reads zero", rv, 32'd0);
        bus_read(8'h09, rv);
        check("R1 misaligned reads zero", rv, 32'd0);
        bus_write(8'h09, 32'h0F0F_0F0F);
        bus_write(8'h48, 32'h0F0F_0F0F);
        bus_read(O_WIN, rv);
        check("R1 unmapped write ignored", rv, 32'd7);

        // Reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read(O_CTRL, rv); check("R9 selects after reset", rv, 32'd0);
        bus_read(O_SUM, rv);  check("R9 result after reset", rv, 32'd0);
        bus_write(O_CTRL, 32'h2);
        bus_read(O_WIN, rv);  check("R9 A after reset", rv, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule